// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block finds the chip-select row of a DRAM array that holds a given physical address. Software programs one boundary value per row; each value is a cumulative upper limit counted in 64 MiB units. Row 0 starts at address zero, and each later row begins where the previous row ends. A row whose limit equals the limit of the row before it holds no memory and is never chosen.

A channel-mode bit sets how many rows are in use. With one channel, all eight rows take part. With two channels, only the lower four rows take part. The block shows which rows currently hold memory as a bit map. It also gives the total installed size, which is the limit of the highest row in use.

Lookups are pipelined. An address presented with a request strobe returns the row index and a hit flag one clock later, together with a response strobe. The lookup uses the boundary values that are in place during the request cycle.

Top module: `row_bound_decoder`

## Requirements
- R1: After reset, every boundary is zero and the mode is single-channel. As a result, `pop_map` is 0, `total_units` is 0 and every lookup misses.
- R2: A write with `cfg_we`=1 and `cfg_sel` in 0..7 stores `cfg_wdata[6:0]` as the boundary of row `cfg_sel`. Bit 7 of `cfg_wdata` is ignored, so 0x85 acts exactly like 0x05.
- R3: A write with `cfg_sel`=8 sets the channel mode from `cfg_wdata[0]`: 0 means single-channel (rows 0..7 in use), 1 means dual-channel (rows 0..3 in use). Writes with `cfg_sel` from 9 to 15 change nothing.
- R4: Bit i of `pop_map` is 1 when row i is in use under the current mode and its boundary differs from the boundary of row i-1. For row 0, the boundary is compared with zero.
- R5: For a lookup, the address unit is `lk_addr >> 26`. A row matches when it is populated and the unit is strictly below its boundary. The lowest-indexed matching row is returned with `rs_hit`=1.
- R6: When no row matches, `rs_hit`=0 and `rs_row`=0. This includes an address at or above the highest boundary in use.
- R7: `rs_valid` is 1 exactly in the cycle after a cycle with `lk_valid`=1. The result is computed from the boundary and mode values held during the request cycle.
- R8: `total_units` equals the boundary of row 7 in single-channel mode and the boundary of row 3 in dual-channel mode.
- R9: In dual-channel mode, rows 4..7 are never reported as populated and are never returned. Their stored values come back into effect when the mode returns to single-channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select: 0..7 row boundary, 8 channel mode |
| cfg_wdata | input | 8 | Write data |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 34 | Physical byte address to decode |
| rs_valid | output | 1 | Lookup result strobe, one cycle after request |
| rs_hit | output | 1 | Address falls inside a populated row |
| rs_row | output | 3 | Selected row index (0 on miss) |
| pop_map | output | 8 | Populated-row bit map under the current mode |
| total_units | output | 7 | Installed memory in 64 MiB units |

## Verification
The hardest cases to reach are two tables that ports alone rarely produce. The first is a non-monotonic table, where a later row has a smaller limit than an earlier one and the lowest-index rule decides the winner. The second is a table whose upper rows are programmed while the mode hides them. The stimulus builds both cases on purpose. It writes row limits while in dual-channel mode and then switches back. It also programs a falling limit after a large one. A long random phase then mixes writes, mode flips and lookups issued in the same cycle as writes. The behavioural model is compared with the design on every clock throughout.

// File: rtl/rbd_pkg.sv
// Shared types for the row boundary decoder.
// Assumes: channel mode is a single bit, where 1 means two channels.
package rbd_pkg;
    typedef enum logic {
        CH_SINGLE = 1'b0,
        CH_DUAL   = 1'b1
    } ch_mode_e;
endpackage

// File: rtl/rbd_bound_regs.sv
// Row boundary register bank and channel-mode register.
// What it does: select values 0..NUM_ROWS-1 write a row limit, select
// NUM_ROWS writes the mode, and any higher select is ignored.
// Assumes: the reserved top bit of the write data is dropped by the caller.
module rbd_bound_regs
    import rbd_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int BND_W    = 7,
    parameter int SEL_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [SEL_W-1:0]               cfg_sel,
    input  logic [BND_W-1:0]               cfg_wdata,
    output logic [NUM_ROWS-1:0][BND_W-1:0] bnd,
    output ch_mode_e                       mode
);
    localparam logic [SEL_W-1:0] MODE_SEL = SEL_W'(NUM_ROWS);

    generate
        for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
            // Hold one row limit; reset makes the row empty.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bnd[g] <= '0;
                else if (cfg_we && cfg_sel == SEL_W'(g))
                    bnd[g] <= cfg_wdata;
            end
        end
    endgenerate

    // Hold the channel mode taken from bit 0 of the write data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= CH_SINGLE;
        else if (cfg_we && cfg_sel == MODE_SEL)
            mode <= ch_mode_e'(cfg_wdata[0]);
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (bnd == '0 && mode == CH_SINGLE));

    // R3
    unused_sel_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel > MODE_SEL) |=> ($stable(bnd) && $stable(mode)));
endmodule

// File: rtl/rbd_row_qual.sv
// Works out which rows are populated and the installed total.
// What it does: a row is populated when it is in use under the mode and its
// limit differs from the limit of the row below it (row 0 is compared with zero).
// Assumes: NUM_ROWS is even; dual-channel mode uses the lower half.
module rbd_row_qual
    import rbd_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int BND_W    = 7
) (
    input  logic [NUM_ROWS-1:0][BND_W-1:0] bnd,
    input  ch_mode_e                       mode,
    output logic [NUM_ROWS-1:0]            pop_map,
    output logic [BND_W-1:0]               total
);
    localparam int HALF = NUM_ROWS / 2;

    generate
        for (genvar g = 0; g < NUM_ROWS; g++) begin : g_pop
            if (g == 0) begin : g_first
                // Row 0 holds memory when its limit is above zero.
                always_comb pop_map[g] = (bnd[g] != '0);
            end else if (g < HALF) begin : g_low
                // Lower rows are in use in both modes.
                always_comb pop_map[g] = (bnd[g] != bnd[g-1]);
            end else begin : g_high
                // Upper rows are in use only with a single channel.
                always_comb pop_map[g] = (mode == CH_SINGLE) && (bnd[g] != bnd[g-1]);
            end
        end
    endgenerate

    // The total is the limit of the highest row in use.
    always_comb total = (mode == CH_DUAL) ? bnd[HALF-1] : bnd[NUM_ROWS-1];
endmodule

// File: rtl/rbd_match.sv
// Compares an address with the row limits and registers the result.
// What it does: finds the lowest populated row whose limit is above the
// address unit and presents it one cycle after the request.
// Assumes: UNIT_W >= BND_W; the result holds its value between requests.
module rbd_match #(
    parameter int NUM_ROWS = 8,
    parameter int BND_W    = 7,
    parameter int UNIT_W   = 8,
    parameter int ROW_W    = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           lk_valid,
    input  logic [UNIT_W-1:0]              lk_unit,
    input  logic [NUM_ROWS-1:0][BND_W-1:0] bnd,
    input  logic [NUM_ROWS-1:0]            pop_map,
    output logic                           rs_valid,
    output logic                           rs_hit,
    output logic [ROW_W-1:0]               rs_row
);
    logic [NUM_ROWS-1:0] below;
    logic [ROW_W-1:0]    sel_row;
    logic                sel_any;

    generate
        for (genvar g = 0; g < NUM_ROWS; g++) begin : g_cmp
            // The row matches when it is populated and the unit lies under its limit.
            always_comb below[g] = pop_map[g] && (lk_unit < UNIT_W'(bnd[g]));
        end
    endgenerate

    // Choose the lowest-indexed matching row.
    always_comb begin
        sel_row = '0;
        sel_any = 1'b0;
        for (int i = NUM_ROWS - 1; i >= 0; i--) begin
            if (below[i]) begin
                sel_row = ROW_W'(i);
                sel_any = 1'b1;
            end
        end
    end

    // Register the decode one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_row   <= '0;
        end else begin
            rs_valid <= lk_valid;
            if (lk_valid) begin
                rs_hit <= sel_any;
                rs_row <= sel_row;
            end
        end
    end

    // R7
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);

    // R7
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);

    // R6
    miss_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_row == '0));

    // R1
    empty_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && pop_map == '0) |=> !rs_hit);
endmodule

// File: rtl/row_bound_decoder.sv
// Top of the row boundary decoder.
// What it does: holds the programmable row limits and mode, and decodes a
// byte address into a row with a one-cycle pipeline.
// Assumes: limits are cumulative and counted in units of 2**GRAIN_SHIFT bytes;
// the top bit of each written byte is reserved.
module row_bound_decoder
    import rbd_pkg::*;
#(
    parameter int NUM_ROWS    = 8,
    parameter int BND_W       = 7,
    parameter int ADDR_W      = 34,
    parameter int GRAIN_SHIFT = 26,
    parameter int SEL_W       = $clog2(NUM_ROWS + 1),
    parameter int ROW_W       = $clog2(NUM_ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [BND_W:0]      cfg_wdata,
    input  logic                lk_valid,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic                rs_valid,
    output logic                rs_hit,
    output logic [ROW_W-1:0]    rs_row,
    output logic [NUM_ROWS-1:0] pop_map,
    output logic [BND_W-1:0]    total_units
);
    localparam int UNIT_W = ADDR_W - GRAIN_SHIFT;
    localparam int HALF   = NUM_ROWS / 2;

    logic [NUM_ROWS-1:0][BND_W-1:0] bnd;
    ch_mode_e                       mode;
    logic [UNIT_W-1:0]              lk_unit;
    logic                           unused_bits;

    // Drop the offset inside a unit and the reserved write bit.
    always_comb begin
        lk_unit     = lk_addr[ADDR_W-1:GRAIN_SHIFT];
        unused_bits = ^{lk_addr[GRAIN_SHIFT-1:0], cfg_wdata[BND_W]};
    end

    rbd_bound_regs #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata[BND_W-1:0]),
        .bnd       (bnd),
        .mode      (mode)
    );

    rbd_row_qual #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W)) u_qual (
        .bnd     (bnd),
        .mode    (mode),
        .pop_map (pop_map),
        .total   (total_units)
    );

    rbd_match #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .UNIT_W(UNIT_W), .ROW_W(ROW_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_valid (lk_valid),
        .lk_unit  (lk_unit),
        .bnd      (bnd),
        .pop_map  (pop_map),
        .rs_valid (rs_valid),
        .rs_hit   (rs_hit),
        .rs_row   (rs_row)
    );

    // R9
    dual_low_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_hit && $past(mode) == CH_DUAL) |-> (rs_row < ROW_W'(HALF)));

    // R5
    hit_row_populated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && pop_map == '0) |=> !(rs_valid && rs_hit));
endmodule

// File: tb/row_bound_decoder_bench.sv
// Bench: behavioural model compared with the design on every clock.
module row_bound_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 8;
    localparam int BW = 7;
    localparam int AW = 34;
    localparam int GS = 26;
    localparam int SW = 4;
    localparam int WATCHDOG = 50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_sel = '0;
    logic [BW:0]   cfg_wdata = '0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          rs_valid, rs_hit;
    logic [2:0]    rs_row;
    logic [NR-1:0] pop_map;
    logic [BW-1:0] total_units;

    row_bound_decoder u_row_bound_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_row(rs_row),
        .pop_map(pop_map), .total_units(total_units)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int    m_bnd [NR];
    bit    m_dual = 1'b0;
    bit    exp_valid = 1'b0;
    bit    exp_hit = 1'b0;
    int    exp_row = 0;
    int    exp_pop = 0;
    int    exp_total = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    string phase = "R1 reset";

    function automatic bit row_used(int i);
        int prev;
        prev = (i == 0) ? 0 : m_bnd[i-1];
        if (m_dual && i >= NR / 2) return 1'b0;
        return m_bnd[i] != prev;
    endfunction

    function automatic void refresh_static();
        exp_pop = 0;
        for (int i = 0; i < NR; i++) if (row_used(i)) exp_pop |= (1 << i);
        exp_total = m_dual ? m_bnd[NR/2-1] : m_bnd[NR-1];
    endfunction

    task automatic check(bit ok, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL [%s] %s actual=%0d expected=%0d", phase, what, act, expv);
        end
    endtask

    // One clock: compare outputs, drive inputs, advance the model.
    task automatic cyc(bit we, int sel, int wdata, bit lv, longint unsigned addr);
        longint unsigned unit;
        check(int'(pop_map) == exp_pop, "R4 pop_map", int'(pop_map), exp_pop);
        check(int'(total_units) == exp_total, "R8 total_units", int'(total_units), exp_total);
        check(rs_valid == exp_valid, "R7 rs_valid", int'(rs_valid), int'(exp_valid));
        if (exp_valid) begin
            check(rs_hit == exp_hit, exp_hit ? "R5 rs_hit" : "R6 rs_hit", int'(rs_hit), int'(exp_hit));
            check(int'(rs_row) == exp_row, exp_hit ? "R5 rs_row" : "R6 rs_row", int'(rs_row), exp_row);
        end
        cfg_we    = we;
        cfg_sel   = sel[SW-1:0];
        cfg_wdata = wdata[BW:0];
        lk_valid  = lv;
        lk_addr   = addr[AW-1:0];
        exp_valid = lv;
        if (lv) begin
            unit = addr >> GS;
            exp_hit = 1'b0;
            exp_row = 0;
            for (int i = 0; i < NR; i++) begin
                if (!exp_hit && row_used(i) && unit < longint'(m_bnd[i])) begin
                    exp_hit = 1'b1;
                    exp_row = i;
                end
            end
        end
        if (we) begin
            if (sel < NR) m_bnd[sel] = wdata & 8'h7F;
            else if (sel == NR) m_dual = wdata[0];
        end
        refresh_static();
        @(negedge clk);
    endtask

    task automatic wr(int sel, int wdata);
        cyc(1'b1, sel, wdata, 1'b0, 0);
    endtask

    task automatic look(int unit, int off);
        cyc(1'b0, 0, 0, 1'b1, (longint'(unit) << GS) + longint'(off));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL [watchdog R7] cycles=%0d expected completion earlier", WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        foreach (m_bnd[i]) m_bnd[i] = 0;
        refresh_static();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset, lookups miss
        phase = "R1 reset";
        look(0, 0);
        look(5, 123);
        cyc(1'b0, 0, 0, 1'b0, 0);

        // R2 / R4 / R5: single-channel table with empty rows 1, 4, 5
        phase = "R2 program";
        wr(0, 2); wr(1, 2); wr(2, 5); wr(3, 9);
        wr(4, 9); wr(5, 9); wr(6, 20); wr(7, 40);
        phase = "R5 single lookup";
        look(0, 0); look(1, (1 << GS) - 1); look(2, 0); look(4, 7);
        look(5, 0); look(8, 99); look(9, 0); look(19, 5);
        look(20, 0); look(39, (1 << GS) - 1);
        phase = "R6 above top";
        look(40, 0); look(200, 1); look(255, (1 << GS) - 1);

        // R2: reserved bit ignored
        phase = "R2 reserved bit";
        wr(2, 8'h85);
        look(4, 0); look(5, 0);
        wr(7, 8'hFF);
        look(126, 0); look(127, 0);
        wr(7, 40);

        // R3 / R9: dual-channel mode hides upper rows
        phase = "R3 mode dual";
        wr(8, 1);
        phase = "R9 dual lookup";
        look(3, 0); look(8, 0); look(9, 0); look(30, 0);
        wr(5, 100);
        look(50, 0);
        phase = "R3 ignored selects";
        for (int s = 9; s < 16; s++) wr(s, 8'hFF);
        look(8, 0);
        phase = "R9 back to single";
        wr(8, 0);
        look(50, 0); look(99, 0); look(100, 0);

        // R5: non-monotonic table, lowest row wins
        phase = "R5 priority";
        wr(0, 10); wr(1, 4);
        for (int i = 2; i < NR; i++) wr(i, 4);
        look(3, 0); look(7, 0); look(12, 0);

        // R7: back-to-back requests and writes in the request cycle
        phase = "R7 pipeline";
        look(1, 0); look(11, 0);
        cyc(1'b1, 0, 0, 1'b1, 64'd5 << GS);
        look(5, 0);
        cyc(1'b0, 0, 0, 1'b0, 0);

        // R4..R9: random mix of writes, mode flips and lookups
        phase = "R5 random mix";
        for (int n = 0; n < 3000; n++) begin
            int  sel;
            int  val;
            bit  we;
            bit  lv;
            we  = ($urandom_range(0, 3) == 0);
            lv  = ($urandom_range(0, 2) != 0);
            sel = $urandom_range(0, 15);
            val = ($urandom_range(0, 3) == 0) ? ((sel > 0 && sel < NR) ? m_bnd[sel-1] : 0)
                                              : $urandom_range(0, 255);
            cyc(we, sel, val, lv,
                (longint'($urandom_range(0, 255)) << GS) + longint'($urandom_range(0, (1 << GS) - 1)));
        end
        cyc(1'b0, 0, 0, 1'b0, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule